// File: doc/BRIEF.md
# Configurable Input Capture Cell

This cell conditions one external input before it reaches the internal routing fabric. Static configuration picks one of four capture styles: straight pass-through, a single edge-triggered register, a two-stage register chain that acts as a synchronizer, or a level-sensitive transparent latch. Any of four global clocks may drive the storage. Each clock has its own polarity bit, and that bit is applied before the clock is chosen.

The configuration inputs are assumed to change only while reset is asserted. The pad and clock inputs are single-bit levels with no handshake. There is no flow control: the cell samples whatever the pad shows at the active clock edge or during the open latch phase. When the build parameter `HAS_CLK_OUT` is set, the cell also forwards the raw pad onto a clock-distribution output so that other cells can use it as a clock source.

Top module: `inmc_cell`

## Requirements
- R1: With mode code 2'b00 (pass-through), `route_o` follows `pad_i` at all times, whatever the clocks do.
- R2: With mode code 2'b01 (single register), `route_o` takes the value of `pad_i` at each active edge of the selected clock and holds it until the next active edge.
- R3: With mode code 2'b10 (two-stage), `route_o` shows the value `pad_i` had two active edges earlier. The first two edges after reset shift in zeros from the cleared stages.
- R4: With mode code 2'b11 (latch), `route_o` follows `pad_i` while the selected clock is at its active level and holds the last value once that level ends.
- R5: `clksel_i` (2 bits) picks `clk_i[clksel_i]` as the capture clock. Activity on the other three clocks has no effect on `route_o`.
- R6: Bit `pol_i[n]` sets the polarity of clock n. With 0, capture happens on the rising edge and the latch is open while the clock is high. With 1, capture happens on the falling edge and the latch is open while the clock is low. Only the polarity bit of the selected clock matters.
- R7: A low level on `rst_n` clears both register stages and the latch to 0 asynchronously. In modes 2'b01, 2'b10 and 2'b11, `route_o` reads 0 while reset is held.
- R8: When `HAS_CLK_OUT` is 1, `gclk_o` equals `pad_i` at all times. When it is 0, `gclk_o` is tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of all storage |
| pad_i | input | DATA_W | External input level |
| clk_i | input | N_CLK | Global clocks |
| pol_i | input | N_CLK | Per-clock polarity, 1 = inverted |
| clksel_i | input | SEL_W | Index of the capture clock |
| mode_i | input | 2 | Capture style code |
| route_o | output | DATA_W | Conditioned value toward the routing fabric |
| gclk_o | output | DATA_W | Pad forwarded to clock distribution (variant) |

## Verification
Two events can land in the same instant: an active edge on the selected clock and a toggle on one of the unselected clocks. Either clock could in principle move the stored value. Each step therefore pulses every unselected clock through a full period with a new pad value present, and then raises the selected clock. The output is judged after each event, against a bench model that only advances on the selected edge. A second overlap is the pad changing while the latch is open compared with after it closes. The bench moves the pad inside the open phase and again after the close. It expects tracking in the first case and a held value in the second. Every mode, clock index and polarity combination is run.

// File: rtl/inmc_pkg.sv
package inmc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_REG   = 2'b01,
    MODE_DUAL  = 2'b10,
    MODE_LATCH = 2'b11
  } cap_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/inmc_clk_pick.sv
module inmc_clk_pick #(
  parameter int unsigned N_CLK = 4,
  parameter int unsigned SEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic [N_CLK-1:0] clk_i,
  input  logic [N_CLK-1:0] pol_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cap_clk_o
);

  logic [N_CLK-1:0] adj_clk;

  // polarity is applied per clock, ahead of the selection
  genvar g;
  generate
    for (g = 0; g < N_CLK; g++) begin : g_pol
      assign adj_clk[g] = clk_i[g] ^ pol_i[g];
    end
  endgenerate

  always_comb begin
    cap_clk_o = 1'b0;
    for (int k = 0; k < N_CLK; k++) begin
      if (sel_i == SEL_W'(k)) cap_clk_o = adj_clk[k];
    end
  end

endmodule

// File: rtl/inmc_store.sv
module inmc_store #(
  parameter int unsigned DATA_W = 1
) (
  input  logic              rst_n,
  input  logic              cap_clk,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] stage1_o,
  output logic [DATA_W-1:0] stage2_o,
  output logic [DATA_W-1:0] latch_o
);

  // two-stage chain; stage1 alone serves single-register mode
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_o <= '0;
      stage2_o <= '0;
    end else begin
      stage1_o <= d_i;
      stage2_o <= stage1_o;
    end
  end

  // transparent while the adjusted clock is high
  always_latch begin
    if (!rst_n)       latch_o = '0;
    else if (cap_clk) latch_o = d_i;
  end

endmodule

// File: rtl/inmc_out_mux.sv
module inmc_out_mux
  import inmc_pkg::*;
#(
  parameter int unsigned DATA_W = 1
) (
  input  cap_mode_e         mode_i,
  input  logic [DATA_W-1:0] pass_i,
  input  logic [DATA_W-1:0] stage1_i,
  input  logic [DATA_W-1:0] stage2_i,
  input  logic [DATA_W-1:0] latch_i,
  output logic [DATA_W-1:0] y_o
);

  always_comb begin
    unique case (mode_i)
      MODE_PASS:  y_o = pass_i;
      MODE_REG:   y_o = stage1_i;
      MODE_DUAL:  y_o = stage2_i;
      MODE_LATCH: y_o = latch_i;
      default:    y_o = pass_i;
    endcase
  end

endmodule

// File: rtl/inmc_cell.sv
module inmc_cell
  import inmc_pkg::*;
#(
  parameter int unsigned DATA_W      = 1,
  parameter int unsigned N_CLK       = 4,
  parameter bit          HAS_CLK_OUT = 1'b1,
  localparam int unsigned SEL_W      = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  pad_i,
  input  logic [N_CLK-1:0]   clk_i,
  input  logic [N_CLK-1:0]   pol_i,
  input  logic [SEL_W-1:0]   clksel_i,
  input  logic [MODE_W-1:0]  mode_i,
  output logic [DATA_W-1:0]  route_o,
  output logic [DATA_W-1:0]  gclk_o
);

  cap_mode_e         mode;
  logic              cap_clk;
  logic [DATA_W-1:0] st1, st2, lat;

  assign mode = cap_mode_e'(mode_i);

  inmc_clk_pick #(.N_CLK(N_CLK), .SEL_W(SEL_W)) u_pick (
    .clk_i     (clk_i),
    .pol_i     (pol_i),
    .sel_i     (clksel_i),
    .cap_clk_o (cap_clk)
  );

  inmc_store #(.DATA_W(DATA_W)) u_store (
    .rst_n    (rst_n),
    .cap_clk  (cap_clk),
    .d_i      (pad_i),
    .stage1_o (st1),
    .stage2_o (st2),
    .latch_o  (lat)
  );

  inmc_out_mux #(.DATA_W(DATA_W)) u_mux (
    .mode_i   (mode),
    .pass_i   (pad_i),
    .stage1_i (st1),
    .stage2_i (st2),
    .latch_i  (lat),
    .y_o      (route_o)
  );

  generate
    if (HAS_CLK_OUT) begin : g_clkout
      assign gclk_o = pad_i;
    end else begin : g_noclk
      assign gclk_o = '0;
    end
  endgenerate

  // edge counter since reset, used only by the checks below
  logic [1:0] edges_seen;
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n)                  edges_seen <= 2'd0;
    else if (edges_seen != 2'd3) edges_seen <= edges_seen + 2'd1;
  end

  AST_PASS_FOLLOWS: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (mode == MODE_PASS) |-> (route_o == pad_i)); // R1

  AST_REG_ONE_EDGE: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (mode == MODE_REG && edges_seen >= 2'd1) |-> (route_o == $past(pad_i))); // R2

  AST_DUAL_TWO_EDGE: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (mode == MODE_DUAL && edges_seen >= 2'd2) |-> (route_o == $past(pad_i, 2))); // R3

  AST_LATCH_CLOSE: assert property (@(negedge cap_clk) disable iff (!rst_n)
    (mode == MODE_LATCH) |-> (route_o == pad_i)); // R4

endmodule

// File: tb/test_inmc_cell.sv
module test_inmc_cell;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [0:0] pad_i;
  logic [3:0] clk_i;
  logic [3:0] pol_i;
  logic [1:0] clksel_i;
  logic [1:0] mode_i;
  logic [0:0] route_o;
  logic [0:0] gclk_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model of the storage
  logic m1, m2, ml;

  always #2.5 clk = ~clk;

  inmc_cell i_inmc_cell (
    .rst_n    (rst_n),
    .pad_i    (pad_i),
    .clk_i    (clk_i),
    .pol_i    (pol_i),
    .clksel_i (clksel_i),
    .mode_i   (mode_i),
    .route_o  (route_o),
    .gclk_o   (gclk_o)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (mode %0d sel %0d pol %b)",
               req, got, exp, mode_i, clksel_i, pol_i);
    end
  endtask

  function automatic logic expect_route(input logic [1:0] m);
    case (m)
      2'b00:   return pad_i[0];
      2'b01:   return m1;
      2'b10:   return m2;
      default: return ml;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // one full combination: mode, clock index, polarity of that clock
  task automatic run_combo(input logic [1:0] m, input int sel, input logic p);
    logic v;
    rst_n = 1'b0;
    #1;
    mode_i   = m;
    clksel_i = 2'(sel);
    pol_i    = 4'($urandom);
    pol_i[sel] = p;
    clk_i    = pol_i;         // every clock parked at its inactive level
    pad_i    = 1'b1;
    m1 = 1'b0; m2 = 1'b0; ml = 1'b0;
    #1;
    if (m != 2'b00) chk("R7 reset clear", route_o[0], 1'b0);
    chk("R8 clock out", gclk_o[0], pad_i[0]);
    rst_n = 1'b1;
    #1;
    for (int s = 0; s < 6; s++) begin
      v = 1'($urandom);
      pad_i = v;
      #1;
      // R5: unselected clocks run a full period
      for (int o = 0; o < 4; o++) begin
        if (o != sel) begin
          clk_i[o] = ~clk_i[o]; #1;
          clk_i[o] = ~clk_i[o]; #1;
        end
      end
      chk(m == 2'b00 ? "R1" : "R5 other clocks", route_o[0], expect_route(m));
      // R6: active edge of the selected clock (raw level moves away from pol)
      clk_i[sel] = ~p;
      m2 = m1; m1 = v; ml = v;
      #1;
      chk(req_of(m), route_o[0], expect_route(m));
      // pad moves inside the open phase
      pad_i = ~v;
      ml = ~v;
      #1;
      chk(m == 2'b11 ? "R4 open" : req_of(m), route_o[0], expect_route(m));
      chk("R8 clock out", gclk_o[0], pad_i[0]);
      // close, then move pad again
      clk_i[sel] = p;
      #1;
      pad_i = v;
      #1;
      chk(m == 2'b11 ? "R4 hold" : "R6 inactive edge", route_o[0], expect_route(m));
    end
    // R7: asynchronous clear with data held
    pad_i = 1'b1;
    rst_n = 1'b0;
    #1;
    if (m != 2'b00) chk("R7 async clear", route_o[0], 1'b0);
    else            chk("R1 in reset", route_o[0], 1'b1);
  endtask

  task automatic run_all;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 2; p++)
          run_combo(2'(m), s, 1'(p));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pad_i = 1'b0; clk_i = '0; pol_i = '0;
    clksel_i = '0; mode_i = '0;
    #10;
    run_all();
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule